// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational binary adder that returns `a + b + cin` as a `WIDTH`-bit sum and a carry-out. The operands are cut into bit groups that widen towards the most significant end. The lowest group is an ordinary ripple adder driven by the external carry-in. Every higher group runs a single ripple adder with its carry-in tied low. An add-one stage of XOR and AND gates turns that result, together with its carry, into the answer the group would give with a carry-in of one. A two-way select, steered by the real carry from the group below, then picks one of the two results. Most of the slow ripple work therefore runs in parallel across groups. The second ripple adder that a textbook carry-select group would need is replaced by the much cheaper add-one stage.

The block holds no state, so it has no clock and no reset. Results follow the inputs within the same combinational settle. It is meant to sit in a datapath wherever an addition must close in a single cycle at 8, 16, 32 or 64 bits.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, `sum` equals the low `WIDTH` bits of `a + b + cin`.
- R2: `cout` is 1 exactly when `a + b + cin` is at least 2^`WIDTH`.
- R3: With `a` and `b` both zero, `sum` equals `cin` zero-extended and `cout` is 0.
- R4: With `a` and `b` both all ones and `cin` = 1, `sum` is all ones and `cout` is 1.
- R5: A carry injected at the bottom travels through every higher bit. For `a` = 2^p − 1, `b` = 0 and `cin` = 1, `sum` is 2^p when p < `WIDTH`. When p = `WIDTH`, `sum` is 0 and `cout` is 1.
- R6: At `WIDTH` = 16 the operands are grouped 2, 2, 3, 4, 5 bits from the LSB, so groups start at bits 0, 2, 4, 7 and 11. A carry made just below each of these starts reaches the bits above it. Other widths continue the sequence 2, 2, 3, 4, … and the top group takes any bits left over.
- R7: In every upper group, the result chosen under a carry-in of 1 equals the carry-in-0 group result, carry included, plus one. This also holds when the carry-in-0 sum is all ones.
- R8: R1 and R2 hold at `WIDTH` = 8, 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
Each fault in this block appears at the outputs in the same evaluation. A faulty add-one stage or select in one group corrupts only that group's slice of `sum`, or the carry it passes upward. It does this only when the real carry into that group takes the faulty value. The bench therefore drives patterns that make the carry-in-0 result of a group all ones and then inject a carry, at every bit position and every width. A fault in the group partition itself only appears when a carry crosses the mis-placed boundary. The 8-bit run is exhaustive, so no such pattern can be missed there.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Number of groups for a given width: sizes 2,2,3,4,... while they fit,
  // any remainder is folded into the last group.
  function automatic int grp_count(input int w);
    int used;
    int n;
    used = 2;
    n    = 1;
    if (w <= 2) return 1;
    while (used + n + 1 <= w) begin
      used = used + n + 1;
      n    = n + 1;
    end
    return n;
  endfunction

  // Bit index where group k starts.
  function automatic int grp_lsb(input int w, input int k);
    int l;
    l = 0;
    for (int j = 0; j < k; j++) l = l + ((j == 0) ? 2 : j + 1);
    return l;
  endfunction

  // Width of group k; the top group absorbs whatever is left.
  function automatic int grp_size(input int w, input int k);
    if (k == grp_count(w) - 1) return w - grp_lsb(w, k);
    return (k == 0) ? 2 : k + 1;
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int N = 2
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);

  logic [N:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[N];

  always_comb begin
    if (!$isunknown({a, b, ci}))
      AST_RIPPLE_EXACT: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci}))
        else $error("ripple chain result wrong"); // R1
  end

endmodule

// File: rtl/csa_plus_one.sv
module csa_plus_one #(
  parameter int N = 2
) (
  input  logic [N:0] x,
  output logic [N:0] y
);

  // ones_below[i] is high when every bit under position i is 1
  logic [N:0] ones_below;
  assign ones_below[0] = 1'b1;

  for (genvar i = 0; i <= N; i++) begin : g_bit
    assign y[i] = x[i] ^ ones_below[i];
    if (i < N) begin : g_chain
      assign ones_below[i+1] = ones_below[i] & x[i];
    end
  end

  always_comb begin
    if (!$isunknown(x))
      AST_PLUS_ONE: assert (y == x + {{N{1'b0}}, 1'b1})
        else $error("add-one stage wrong"); // R7
  end

endmodule

// File: rtl/csa_select_group.sv
module csa_select_group #(
  parameter int N = 2
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  logic [N-1:0] s_lo;
  logic         c_lo;
  logic [N:0]   r_hi;

  csa_ripple #(.N(N)) u_rca (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (s_lo),
    .co (c_lo)
  );

  csa_plus_one #(.N(N)) u_inc (
    .x ({c_lo, s_lo}),
    .y (r_hi)
  );

  assign {cout, sum} = cin ? r_hi : {c_lo, s_lo};

  always_comb begin
    if (!$isunknown({a, b, cin}))
      AST_GROUP_SELECT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
        else $error("group selection wrong"); // R7
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG = csa_pkg::grp_count(WIDTH);
  localparam int G0 = csa_pkg::grp_size(WIDTH, 0);

  // carry[k] enters group k; carry[NG] leaves the top group
  logic [NG:0] carry;
  assign carry[0] = cin;

  csa_ripple #(.N(G0)) u_grp0 (
    .a  (a[G0-1:0]),
    .b  (b[G0-1:0]),
    .ci (carry[0]),
    .s  (sum[G0-1:0]),
    .co (carry[1])
  );

  for (genvar k = 1; k < NG; k++) begin : g_grp
    localparam int LSB = csa_pkg::grp_lsb(WIDTH, k);
    localparam int SZ  = csa_pkg::grp_size(WIDTH, k);
    csa_select_group #(.N(SZ)) u_sel (
      .a    (a[LSB+SZ-1:LSB]),
      .b    (b[LSB+SZ-1:LSB]),
      .cin  (carry[k]),
      .sum  (sum[LSB+SZ-1:LSB]),
      .cout (carry[k+1])
    );
  end

  assign cout = carry[NG];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      AST_SUM_EXACT: assert (sum == WIDTH'({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("sum wrong"); // R1
      AST_CARRY_OUT: assert (cout == (({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}) >> WIDTH))
        else $error("carry-out wrong"); // R2
    end
  end

endmodule

// File: tb/test_sqrt_csel_adder.sv
module test_sqrt_csel_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NRAND      = 2000;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R3
    '{16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0}, // R3
    '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1}, // R2
    '{16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1}, // R4
    '{16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1}, // R5
    '{16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0}, // R1
    '{16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1}, // R2
    '{16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0}, // R1
    '{16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0}, // R5
    '{16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1}, // R7
    '{16'h0003, 16'h0000, 1'b1, 16'h0004, 1'b0}, // R6 boundary at bit 2
    '{16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0}, // R6 boundary at bit 4
    '{16'h07FF, 16'h0001, 1'b0, 16'h0800, 1'b0}  // R6 boundary at bit 11
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  a8,  b8,  s8;   logic c8,  co8;
  logic [15:0] a16, b16, s16;  logic c16, co16;
  logic [31:0] a32, b32, s32;  logic c32, co32;
  logic [63:0] a64, b64, s64;  logic c64, co64;

  sqrt_csel_adder #(.WIDTH(16)) i_sqrt_csel_adder (
    .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  sqrt_csel_adder #(.WIDTH(8))  i_sqrt_csel_adder_w8 (
    .a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  sqrt_csel_adder #(.WIDTH(32)) i_sqrt_csel_adder_w32 (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  sqrt_csel_adder #(.WIDTH(64)) i_sqrt_csel_adder_w64 (
    .a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64));

  task automatic report(input string tag, input int w, input logic [64:0] got,
                        input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s width=%0d actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  // Drive one width, let it settle mid-cycle, compare against a + b + cin.
  task automatic run(input int w, input logic [63:0] a, input logic [63:0] b,
                     input logic cin, input string tag);
    logic [64:0] mask, exp, got;
    mask = (w == 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
    exp  = ({1'b0, a & mask[63:0]} + {1'b0, b & mask[63:0]} + {64'd0, cin});
    @(posedge clk);
    #1;
    case (w)
      8:       begin a8  = a[7:0];  b8  = b[7:0];  c8  = cin; end
      16:      begin a16 = a[15:0]; b16 = b[15:0]; c16 = cin; end
      32:      begin a32 = a[31:0]; b32 = b[31:0]; c32 = cin; end
      default: begin a64 = a;       b64 = b;       c64 = cin; end
    endcase
    #2;
    case (w)
      8:       got = {56'd0, co8,  s8};
      16:      got = {48'd0, co16, s16};
      32:      got = {32'd0, co32, s32};
      default: got = {co64, s64};
    endcase
    report(tag, w, got, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    a8 = '0;  b8 = '0;  c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;

    // idle state: zero operands give zero at every width (R3)
    @(posedge clk); #3;
    report("R3 idle w8",  8,  {56'd0, co8,  s8},  65'd0);
    report("R3 idle w16", 16, {48'd0, co16, s16}, 65'd0);
    report("R3 idle w32", 32, {32'd0, co32, s32}, 65'd0);
    report("R3 idle w64", 64, {co64, s64},        65'd0);

    // table walk at 16 bits, expected values taken from the table
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      a16 = VECS[i].a; b16 = VECS[i].b; c16 = VECS[i].cin;
      #2;
      report($sformatf("R1/R6 table row %0d", i), 16, {48'd0, co16, s16},
             {48'd0, VECS[i].cout, VECS[i].sum});
    end

    // R4, R3 at every width
    run(8,  {64{1'b1}}, {64{1'b1}}, 1'b1, "R4 all ones");
    run(32, {64{1'b1}}, {64{1'b1}}, 1'b1, "R4 all ones");
    run(64, {64{1'b1}}, {64{1'b1}}, 1'b1, "R4 all ones");
    run(32, 64'd0, 64'd0, 1'b1, "R3 carry-in only");
    run(64, 64'd0, 64'd0, 1'b1, "R3 carry-in only");

    // R5 / R7: carry crossing every bit position, hence every group boundary
    for (int p = 0; p <= 8; p++)  run(8,  (64'd1 << p) - 64'd1, 64'd0, 1'b1, "R5 R7 propagate");
    for (int p = 0; p <= 16; p++) run(16, (64'd1 << p) - 64'd1, 64'd0, 1'b1, "R5 R7 propagate");
    for (int p = 0; p <= 32; p++) run(32, (64'd1 << p) - 64'd1, 64'd0, 1'b1, "R5 R7 propagate");
    for (int p = 0; p < 64; p++)  run(64, (64'd1 << p) - 64'd1, 64'd0, 1'b1, "R5 R7 propagate");
    run(64, {64{1'b1}}, 64'd0, 1'b1, "R5 R7 propagate full");
    // generated carry instead of injected one
    for (int p = 1; p < 64; p++)  run(64, (64'd1 << p) - 64'd1, 64'd1, 1'b0, "R6 R7 generate");

    // R8: exhaustive at 8 bits
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          run(8, 64'(x), 64'(y), c[0], "R8 R1 R2 exhaustive");
        end
      end
    end

    // R8: random at the wider widths
    for (int n = 0; n < NRAND; n++) run(16, {32'd0, $urandom}, {32'd0, $urandom}, $urandom % 2 == 1, "R8 R1 R2 random");
    for (int n = 0; n < NRAND; n++) run(32, {32'd0, $urandom}, {32'd0, $urandom}, $urandom % 2 == 1, "R8 R1 R2 random");
    for (int n = 0; n < NRAND; n++) run(64, {$urandom, $urandom}, {$urandom, $urandom}, $urandom % 2 == 1, "R8 R1 R2 random");

    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

endmodule